// File: doc/BRIEF.md
# SPI Burst Master with Register Interface

This block is an SPI master run entirely from a small word-addressed register file. Software places outgoing bytes in a byte-wide transmit FIFO, writes how many bytes the burst should contain, and then sets a start bit. The controller clocks that many bytes out on the serial data output, most significant bit first. Each byte it shifts out brings one byte in from the serial data input, and that byte goes into a receive FIFO. When the last byte completes, the start bit drops back to zero by itself and a sticky completion flag is raised, so software can poll either one.

Clock polarity and phase are programmable. The chip-select line can follow the burst automatically. It can also be handed to software, which then sets its level directly and may keep the slave selected across several bursts. A global register gates the whole controller: a start request is accepted only while both the enable bit and the master bit are set.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, csN is 1 and sclk is 0. The receive FIFO is empty. Word 0 reads {VER_MAJOR[15:0], VER_MINOR[15:0]}, which is 0x00010003 by default.
- R2: Writing bit 31 of word 2 (transfer control) starts a burst only if word 1 has bit 0 (enable) and bit 1 (master) both set. Otherwise the write is ignored: bit 31 reads 0 and sclk does not toggle.
- R3: A burst of N bytes sends N transmit-FIFO bytes MSB first and places N received bytes in the receive FIFO, in order. Bit 31 of word 2 reads 1 while the burst runs and clears itself when the burst ends.
- R4: Bit 12 of word 3 (status) sets when a burst ends. Writing 1 to it clears it, and writing 0 to it has no effect.
- R5: Bit 1 of word 2 is CPOL and bit 0 is CPHA. sclk rests at the CPOL level. With CPHA=0 data is sampled on the first (leading) edge of each bit; with CPHA=1 it is sampled on the second (trailing) edge.
- R6: When bit 6 of word 2 is 0, csN is driven low for the length of a burst and is 1 at all other times.
- R7: When bit 6 of word 2 is 1, csN equals bit 7 of word 2 and keeps that level across bursts.
- R8: The burst length in word 5 is clamped to DEPTH (64). A length of 0 completes at once, with no sclk edges.
- R9: A write to word 6 (TX data) while the transmit FIFO is full is ignored. Bit 0 of word 3 reads 1 when the transmit FIFO is full.
- R10: Bit 1 of word 3 reads 1 when the receive FIFO is empty. Reading word 7 pops one received byte, and reads 0 when the FIFO is empty.
- R11: Writing 1 to bit 31 of word 4 empties the transmit FIFO. Writing 1 to bit 15 of word 4 empties the receive FIFO.
- R12: If the transmit FIFO runs dry during a burst, 0x00 is shifted out for each missing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of word 7 pops the receive FIFO) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Chip select, active low |

## Verification
The hardest state to reach from the ports is the FIFO boundary. The transmit FIFO must be exactly full with one more write arriving, and then a burst length beyond the depth must be requested. The stimulus makes 65 writes, checks the full flag before the last one, and starts a burst of 100. It then shows that exactly 64 bytes reach the wire. A following burst with nothing queued sends 0x00, which proves the extra write was dropped. A slave model in the bench follows CPOL/CPHA independently, so all four modes, including the CPHA=1 byte hand-over on the leading edge, are checked against its own sampling.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [2:0] {
    ADDR_VER  = 3'd0,
    ADDR_GLB  = 3'd1,
    ADDR_XFER = 3'd2,
    ADDR_STAT = 3'd3,
    ADDR_FIFO = 3'd4,
    ADDR_CNT  = 3'd5,
    ADDR_TXD  = 3'd6,
    ADDR_RXD  = 3'd7
  } regAddrE;

  localparam int BIT_START   = 31;
  localparam int BIT_CSLVL   = 7;
  localparam int BIT_CSOWN   = 6;
  localparam int BIT_CPOL    = 1;
  localparam int BIT_CPHA    = 0;
  localparam int BIT_DONE    = 12;
  localparam int BIT_RXEMPTY = 1;
  localparam int BIT_TXFULL  = 0;
  localparam int BIT_TXRST   = 31;
  localparam int BIT_RXRST   = 15;

  // control -> datapath strobes
  typedef struct packed {
    logic       txPush;
    logic       txFlush;
    logic       rxPop;
    logic       rxFlush;
    logic       start;
    logic       cpol;
    logic       cpha;
    logic [7:0] wrByte;
  } ctrlStrobeT;

  // datapath -> control status
  typedef struct packed {
    logic       busy;
    logic       done;
    logic       txFull;
    logic       rxEmpty;
    logic [7:0] rxHead;
  } dpStatusT;

endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    fill;
  logic             doPush, doPop;

  assign empty  = (fill == '0);
  assign full   = (fill == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      fill <= fill + CW'(doPush) - CW'(doPop);
    end
  end

  // R9: a push into a full FIFO leaves the fill level unchanged
  a_r9_full_push_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> $stable(fill));

endmodule

// File: rtl/spi_burst_datapath.sv
module spi_burst_datapath
  import spi_burst_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int HALF_CYCLES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [CNT_W-1:0] burstLen,
  input  logic             miso,
  output dpStatusT         stat,
  output logic             sclk,
  output logic             mosi
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(HALF_CYCLES) + 1;

  logic [7:0]    txHead, rxPushData, txSh, rxSh, rxNext, loadVal;
  logic          txEmpty, txFull, rxEmpty, rxFull;
  logic          busy, tail, done, sclkR, cphaR, cpolR;
  logic [3:0]    edgeCnt;
  logic [TW-1:0] timer;
  logic [CW-1:0] bytesLeft, clampLen;
  logic          tick, edgeNow, even, sampleNow, shiftNow, lastEdge, loadByte;
  logic          startGo, zeroDone;

  spi_burst_fifo #(.DEPTH(DEPTH), .WIDTH(8)) uTxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush), .push(strobe.txPush),
    .pop(loadByte), .wrData(strobe.wrByte), .rdData(txHead),
    .empty(txEmpty), .full(txFull));

  spi_burst_fifo #(.DEPTH(DEPTH), .WIDTH(8)) uRxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush), .push(lastEdge),
    .pop(strobe.rxPop), .wrData(rxPushData), .rdData(stat.rxHead),
    .empty(rxEmpty), .full(rxFull));

  assign clampLen = (burstLen > CNT_W'(DEPTH)) ? CW'(DEPTH) : CW'(burstLen);
  assign startGo  = strobe.start && !busy && (burstLen != '0);
  assign zeroDone = strobe.start && !busy && (burstLen == '0);
  assign tick     = (timer == TW'(HALF_CYCLES - 1));
  assign loadVal  = txEmpty ? 8'h00 : txHead;
  assign rxNext   = {rxSh[6:0], miso};
  assign rxPushData = cphaR ? rxNext : rxSh;

  always_comb begin
    edgeNow   = busy && !tail && tick;
    even      = ~edgeCnt[0];
    sampleNow = edgeNow && (cphaR ? !even : even);
    lastEdge  = edgeNow && (edgeCnt == 4'd15);
    shiftNow  = edgeNow && (cphaR ? (even && edgeCnt != 4'd0)
                                  : (!even && edgeCnt != 4'd15));
    loadByte  = 1'b0;
    if (startGo && !strobe.cpha) loadByte = 1'b1;
    if (edgeNow && cphaR && edgeCnt == 4'd0) loadByte = 1'b1;
    if (lastEdge && !cphaR && bytesLeft != CW'(1)) loadByte = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; tail <= 1'b0; done <= 1'b0;
      edgeCnt <= '0; timer <= '0; bytesLeft <= '0;
      txSh <= '0; rxSh <= '0; sclkR <= 1'b0; cphaR <= 1'b0; cpolR <= 1'b0;
    end else begin
      done <= 1'b0;
      if (loadByte)      txSh <= loadVal;
      else if (shiftNow) txSh <= {txSh[6:0], 1'b0};
      if (sampleNow)     rxSh <= rxNext;
      if (!busy) begin
        sclkR   <= strobe.cpol;
        timer   <= '0;
        edgeCnt <= '0;
        if (startGo) begin
          busy      <= 1'b1;
          tail      <= 1'b0;
          bytesLeft <= clampLen;
          cphaR     <= strobe.cpha;
          cpolR     <= strobe.cpol;
        end
        if (zeroDone) done <= 1'b1;
      end else if (tick) begin
        timer <= '0;
        if (tail) begin
          busy <= 1'b0;
          tail <= 1'b0;
          done <= 1'b1;
        end else begin
          sclkR   <= ~sclkR;
          edgeCnt <= edgeCnt + 4'd1;
          if (edgeCnt == 4'd15) begin
            bytesLeft <= bytesLeft - CW'(1);
            if (bytesLeft == CW'(1)) tail <= 1'b1;
          end
        end
      end else begin
        timer <= timer + TW'(1);
      end
    end
  end

  assign sclk         = sclkR;
  assign mosi         = txSh[7];
  assign stat.busy    = busy;
  assign stat.done    = done;
  assign stat.txFull  = txFull;
  assign stat.rxEmpty = rxEmpty;

  // R5: every burst leaves the clock back at its polarity level
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (sclk == cpolR));

  wire unusedRxFull = rxFull;

endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter logic [15:0] VER_MAJOR = 16'd1,
  parameter logic [15:0] VER_MINOR = 16'd3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output ctrlStrobeT       strobe,
  output logic [CNT_W-1:0] burstLen,
  input  dpStatusT         stat,
  output logic             csN
);
  logic enR, masterR, cphaR, cpolR, csOwnR, csLvlR, startR, doneR;
  logic [CNT_W-1:0] cntR;
  logic wrXfer, startReq;

  assign wrXfer   = regWrEn && (regAddr == ADDR_XFER);
  assign startReq = wrXfer && regWrData[BIT_START] && enR && masterR && !startR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR <= 1'b0; masterR <= 1'b0; cphaR <= 1'b0; cpolR <= 1'b0;
      csOwnR <= 1'b0; csLvlR <= 1'b1; startR <= 1'b0; doneR <= 1'b0;
      cntR <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_GLB) begin
        enR     <= regWrData[0];
        masterR <= regWrData[1];
      end
      if (wrXfer) begin
        cphaR  <= regWrData[BIT_CPHA];
        cpolR  <= regWrData[BIT_CPOL];
        csOwnR <= regWrData[BIT_CSOWN];
        csLvlR <= regWrData[BIT_CSLVL];
      end
      if (regWrEn && regAddr == ADDR_CNT) cntR <= regWrData[CNT_W-1:0];
      if (stat.done)     startR <= 1'b0;
      else if (startReq) startR <= 1'b1;
      if (stat.done) doneR <= 1'b1;
      else if (regWrEn && regAddr == ADDR_STAT && regWrData[BIT_DONE]) doneR <= 1'b0;
    end
  end

  always_comb begin
    strobe.txPush  = regWrEn && (regAddr == ADDR_TXD);
    strobe.wrByte  = regWrData[7:0];
    strobe.txFlush = regWrEn && (regAddr == ADDR_FIFO) && regWrData[BIT_TXRST];
    strobe.rxFlush = regWrEn && (regAddr == ADDR_FIFO) && regWrData[BIT_RXRST];
    strobe.rxPop   = regRdEn && (regAddr == ADDR_RXD);
    strobe.start   = startReq;
    strobe.cpha    = wrXfer ? regWrData[BIT_CPHA] : cphaR;
    strobe.cpol    = wrXfer ? regWrData[BIT_CPOL] : cpolR;
  end

  assign burstLen = cntR;
  assign csN      = csOwnR ? csLvlR : !stat.busy;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_VER:  regRdData = {VER_MAJOR, VER_MINOR};
      ADDR_GLB:  regRdData[1:0] = {masterR, enR};
      ADDR_XFER: begin
        regRdData[BIT_START] = startR;
        regRdData[BIT_CSLVL] = csLvlR;
        regRdData[BIT_CSOWN] = csOwnR;
        regRdData[BIT_CPOL]  = cpolR;
        regRdData[BIT_CPHA]  = cphaR;
      end
      ADDR_STAT: begin
        regRdData[BIT_DONE]    = doneR;
        regRdData[BIT_RXEMPTY] = stat.rxEmpty;
        regRdData[BIT_TXFULL]  = stat.txFull;
      end
      ADDR_CNT:  regRdData[CNT_W-1:0] = cntR;
      ADDR_RXD:  regRdData[7:0] = stat.rxEmpty ? 8'h00 : stat.rxHead;
      default:   regRdData = '0;
    endcase
  end

  // R2: a burst is only accepted while the controller is enabled as master
  a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startR) |-> (enR && masterR));

  // R4: the start bit never drops without the completion flag being set
  a_r4_done_on_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startR) |-> doneR);

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          HALF_CYCLES = 2,
  parameter int          CNT_W       = 16,
  parameter logic [15:0] VER_MAJOR   = 16'd1,
  parameter logic [15:0] VER_MINOR   = 16'd3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csN
);
  ctrlStrobeT       strobe;
  dpStatusT         stat;
  logic [CNT_W-1:0] burstLen;

  spi_burst_ctrl #(.CNT_W(CNT_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .burstLen(burstLen), .stat(stat), .csN(csN));

  spi_burst_datapath #(.DEPTH(DEPTH), .HALF_CYCLES(HALF_CYCLES), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .burstLen(burstLen),
    .miso(miso), .stat(stat), .sclk(sclk), .mosi(mosi));

endmodule

// File: tb/spi_burst_master_test.sv
`timescale 1ns/1ps
module spi_burst_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        sclk, mosi, miso, csN;

  int checks = 0, fails = 0, edgeCount = 0;
  bit runDone = 1'b0;
  logic [7:0] expMosiQ[$];
  int expRxIdx = 0;

  // slave model state
  logic slvCpol = 1'b0, slvCpha = 1'b0;
  logic [2:0] slvBit = '0;
  logic [7:0] slvShift = '0;
  int slvIdx = 0;
  logic [7:0] slvCur;

  always #4 clk = ~clk;  // 125 MHz

  spi_burst_master uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN));

  function automatic logic [7:0] slvByte(input int i);
    return 8'((i * 37 + 91) & 255);
  endfunction

  assign slvCur = slvByte(slvIdx);
  assign miso   = slvCur[3'd7 - slvBit];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: independent slave sampling per CPOL/CPHA, compared with scoreboard
  always @(sclk) begin
    edgeCount++;
    if (csN === 1'b0) begin
      if (slvCpha ? (sclk == slvCpol) : (sclk != slvCpol)) begin
        slvShift = {slvShift[6:0], mosi};
        slvBit++;
        if (slvBit == 3'd0) begin
          slvIdx++;
          if (expMosiQ.size() == 0) check(1'b0, "R3 unexpected byte on wire", {24'h0, slvShift}, 32'h0);
          else begin
            logic [7:0] e;
            e = expMosiQ.pop_front();
            check(slvShift == e, "R3/R5 mosi byte", {24'h0, slvShift}, {24'h0, e});
          end
        end
      end
    end
  end
  always @(negedge csN) slvBit = '0;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic pushBytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 29) & 255);
      wr(3'd6, {24'h0, b});
      expMosiQ.push_back(b);
    end
  endtask

  // driver: start a burst, wait for self-clearing start bit, read back RX
  task automatic runBurst(input int cnt, input logic [31:0] ctl, input int nRx, input string tag);
    logic [31:0] d;
    int polls;
    wr(3'd5, 32'(cnt));
    wr(3'd2, ctl | 32'h8000_0000);
    if (!ctl[6] && nRx > 0) check(csN == 1'b0, {tag, " R6 csN low in burst"}, {31'h0, csN}, 32'h0);
    polls = 0;
    d = 32'h8000_0000;
    while (d[31] && polls < 5000) begin rd(3'd2, d); polls++; end
    check(d[31] == 1'b0, {tag, " R3 start self-clears"}, d, 32'h0);
    rd(3'd3, d);
    check(d[12] == 1'b1, {tag, " R4 done set"}, d, 32'h1000);
    if (!ctl[6]) check(csN == 1'b1, {tag, " R6 csN released"}, {31'h0, csN}, 32'h1);
    for (int i = 0; i < nRx; i++) begin
      rd(3'd7, d);
      check(d[7:0] == slvByte(expRxIdx), {tag, " R3 rx byte"}, d, {24'h0, slvByte(expRxIdx)});
      expRxIdx++;
    end
    wr(3'd3, 32'h1000);
  endtask

  task automatic setMode(input logic cpol, input logic cpha);
    slvCpol = cpol; slvCpha = cpha;
    wr(3'd2, {30'h0, cpol, cpha});
    repeat (3) @(negedge clk);
    check(sclk == cpol, "R5 sclk idles at CPOL", {31'h0, sclk}, {31'h0, cpol});
  endtask

  initial begin
    logic [31:0] d;
    int e0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b0, "R1 reset pins", {30'h0, csN, sclk}, 32'h2);
    rd(3'd0, d);
    check(d == 32'h0001_0003, "R1 version", d, 32'h0001_0003);
    rd(3'd3, d);
    check(d[1] == 1'b1 && d[12] == 1'b0, "R1/R10 reset status", d, 32'h2);

    // R2: start while disabled is ignored
    wr(3'd6, 32'h77);
    wr(3'd5, 32'd1);
    e0 = edgeCount;
    wr(3'd2, 32'h8000_0000);
    repeat (80) @(negedge clk);
    rd(3'd2, d);
    check(d[31] == 1'b0, "R2 start ignored when disabled", d, 32'h0);
    check(edgeCount == e0, "R2 no sclk activity", 32'(edgeCount - e0), 32'h0);
    wr(3'd1, 32'h1);  // enable without master
    wr(3'd2, 32'h8000_0000);
    repeat (40) @(negedge clk);
    rd(3'd2, d);
    check(d[31] == 1'b0 && edgeCount == e0, "R2 start ignored without master", d, 32'h0);
    // R11: TX reset drops the stale byte
    wr(3'd4, 32'h8000_8000);
    wr(3'd1, 32'h3);

    // R3/R6: mode 0, auto chip select
    setMode(1'b0, 1'b0);
    pushBytes(4, 8'h3C);
    runBurst(4, 32'h0, 4, "mode0");
    // R11: byte from before reset must not appear; burst of 1 sends 0x00 (R12)
    expMosiQ.push_back(8'h00);
    runBurst(1, 32'h0, 1, "R11/R12 tx flushed");

    // R4: write 0 leaves done, write 1 clears
    wr(3'd5, 32'd0);
    wr(3'd2, 32'h8000_0000);
    repeat (5) @(negedge clk);
    wr(3'd3, 32'h0);
    rd(3'd3, d);
    check(d[12] == 1'b1, "R4 write 0 no effect", d, 32'h1000);
    wr(3'd3, 32'h1000);
    rd(3'd3, d);
    check(d[12] == 1'b0, "R4 write 1 clears", d, 32'h0);

    // R5: remaining modes
    setMode(1'b0, 1'b1);
    pushBytes(3, 8'h91);
    runBurst(3, 32'h1, 3, "mode1");
    setMode(1'b1, 1'b0);
    pushBytes(3, 8'hE4);
    runBurst(3, 32'h2, 3, "mode2");
    setMode(1'b1, 1'b1);
    pushBytes(3, 8'h0F);
    runBurst(3, 32'h3, 3, "mode3");

    // R7: manual chip select held across bursts
    setMode(1'b0, 1'b0);
    wr(3'd2, 32'h40);
    @(negedge clk);
    check(csN == 1'b0, "R7 manual assert", {31'h0, csN}, 32'h0);
    pushBytes(2, 8'h55);
    runBurst(2, 32'h40, 2, "manual1");
    check(csN == 1'b0, "R7 held after burst", {31'h0, csN}, 32'h0);
    pushBytes(2, 8'hA2);
    runBurst(2, 32'h40, 2, "manual2");
    check(csN == 1'b0, "R7 held after second burst", {31'h0, csN}, 32'h0);
    wr(3'd2, 32'hC0);
    @(negedge clk);
    check(csN == 1'b1, "R7 manual release", {31'h0, csN}, 32'h1);
    wr(3'd2, 32'h0);

    // R8/R9: fill FIFO, extra write dropped, length clamped
    pushBytes(64, 8'h11);
    rd(3'd3, d);
    check(d[0] == 1'b1, "R9 tx full flag", d, 32'h1);
    wr(3'd6, 32'hEE);
    runBurst(100, 32'h0, 64, "R8 clamp");
    rd(3'd7, d);
    check(d == 32'h0, "R10 empty rx reads 0", d, 32'h0);
    rd(3'd3, d);
    check(d[1] == 1'b1, "R10 rx empty flag", d, 32'h2);
    expMosiQ.push_back(8'h00);
    runBurst(1, 32'h0, 1, "R9/R12 extra write dropped");

    // R8: zero length
    e0 = edgeCount;
    runBurst(0, 32'h0, 0, "R8 zero length");
    check(edgeCount == e0, "R8 zero length no edges", 32'(edgeCount - e0), 32'h0);

    // R11: RX reset
    pushBytes(1, 8'h42);
    runBurst(1, 32'h0, 0, "R11 prep");
    rd(3'd3, d);
    check(d[1] == 1'b0, "R11 rx holds byte", d, 32'h0);
    wr(3'd4, 32'h0000_8000);
    rd(3'd3, d);
    check(d[1] == 1'b1, "R11 rx reset empties", d, 32'h2);

    check(expMosiQ.size() == 0, "R3 all expected bytes seen", 32'(expMosiQ.size()), 32'h0);
    runDone = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!runDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule